// File: doc/BRIEF.md
# Debug Trigger and Trace Controller

This block sits beside a processor core and watches two buses: the instruction-fetch address bus and the data bus, which carries an address, a data value and separate read and write strobes. A small bank of programmable comparators is evaluated on every cycle. A comparator, or a chain of comparators ANDed together, fires a debug action when it matches. The actions are:

- a break request that halts the core,
- a pulse on an external trigger output,
- trace switched on or off,
- one captured trace sample,
- arming, which enables the comparators that wait for it.

Each comparator has a control word, an address value and a data value, written through a plain register write port. Two neighbouring comparators can form an inclusive range: the lower one holds the low bounds and the upper one the high bounds. Arming gives a two-level sequence, in which event B is honoured only after event A. Every action appears one cycle after the bus cycle that caused it. Trace samples leave on a valid/ready output. While `trc_valid` is high and `trc_ready` is low, the sample is held unchanged and new samples are dropped. A sample is consumed on any edge where both are high, and a new sample may load on that same edge.

Top module: `dbg_trigger_ctl`

## Requirements

- R1: After reset every comparator is disabled, the block is not armed, and `brk_req`, `ext_trig`, `trace_en` and `trc_valid` are low.
- R2: Configuration: with `cfg_we` high, `cfg_sel` picks the register of comparator `cfg_idx`:
  - 0 is the control word, 1 is the address value, 2 is the data value, and 3 is a command that clears the armed state.
  - Control word bits: [0] enable, [1] bus (0 = instruction, 1 = data), [4:2] match kind, [5] AND-link to the next comparator, [6] requires-armed, [9:7] action.
- R3: Match kinds are 0 address-equal, 1 data-equal, 2 read cycle, 3 write cycle, 4 address range, 5 data range and 6 address-and-data range. On the instruction bus, only kinds 0 and 4 can match, and only while `if_valid` is high. On the data bus, a kind can match only while `d_rd` or `d_wr` is high.
- R4: An enabled instruction-bus address comparator with action 0 (break) raises `brk_req` for one cycle, in the cycle after the matching fetch. A data access to the same address has no effect.
- R5: A comparator whose link bit is set is ANDed with the next one. The last comparator of a chain supplies the action. A chain fires only if all its members match in the same cycle and all of them watch the same bus.
- R6: A range comparator at index i uses its own values as lower bounds and the values of comparator i+1 as upper bounds, inclusive at both ends. The last comparator's range never matches.
- R7: A comparator with requires-armed set fires only if an arm action (5) took effect on an earlier cycle. The armed state persists until a clear command is written.
- R8: Action 1 pulses `ext_trig` for one cycle. Action 2 sets `trace_en` and action 3 clears it. When both happen in the same cycle, the clear wins.
- R9: Action 4 captures `d_addr`, `d_data` and `d_wr` into `trc_addr`, `trc_data` and `trc_wr` and raises `trc_valid`. An instruction-bus comparator with action 4 produces no sample.
- R10: While `trc_valid` is high and `trc_ready` is low, the sample fields stay stable and new samples are dropped. A handshake with no new sample lowers `trc_valid`.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Comparator index |
| cfg_sel | input | 2 | Register select (control, address, data, clear-arm) |
| cfg_wdata | input | 32 | Configuration write data |
| if_valid | input | 1 | Instruction fetch address valid |
| if_addr | input | 32 | Instruction fetch address |
| d_rd | input | 1 | Data bus read strobe |
| d_wr | input | 1 | Data bus write strobe |
| d_addr | input | 32 | Data bus address |
| d_data | input | 32 | Data bus value |
| brk_req | output | 1 | Break request pulse |
| ext_trig | output | 1 | External trigger pulse |
| trace_en | output | 1 | Trace enable level |
| trc_valid | output | 1 | Trace sample valid |
| trc_ready | input | 1 | Trace sample accepted by consumer |
| trc_addr | output | 32 | Captured data-bus address |
| trc_data | output | 32 | Captured data-bus value |
| trc_wr | output | 1 | Captured access was a write |

## Verification

Each match kind is driven with a hitting access and with a near miss: an address one off, a value one off, and the opposite strobe. These separate exact compares from loose ones. Ranges are probed at both bounds and one step outside each, which exposes off-by-one and inclusive/exclusive mistakes. Linked chains are fed accesses where only one member matches, and accesses where the members sit on different buses; these show whether the AND and the bus check are present. The arm sequence hits event B first, then A, then B twice, and then B again after a clear command. This pins down ordering and persistence. Trace samples are issued under back-pressure, and one is issued from the instruction bus, to show the drop rule and the data-bus-only rule.

// File: rtl/dbgtrig_pkg.sv
package dbgtrig_pkg;

  typedef enum logic [2:0] {
    K_ADDR     = 3'd0,
    K_DATA     = 3'd1,
    K_READ     = 3'd2,
    K_WRITE    = 3'd3,
    K_RNG_ADDR = 3'd4,
    K_RNG_DATA = 3'd5,
    K_RNG_BOTH = 3'd6,
    K_NONE     = 3'd7
  } match_kind_e;

  typedef enum logic [2:0] {
    A_BREAK     = 3'd0,
    A_EXTTRIG   = 3'd1,
    A_TRACE_ON  = 3'd2,
    A_TRACE_OFF = 3'd3,
    A_SAMPLE    = 3'd4,
    A_ARM       = 3'd5,
    A_NOP6      = 3'd6,
    A_NOP7      = 3'd7
  } act_e;

  // control word layout: [9:7] action [6] need_arm [5] link [4:2] kind [1] bus [0] enable
  typedef struct packed {
    act_e        action;
    logic        need_arm;
    logic        link;
    match_kind_e kind;
    logic        on_dbus;
    logic        enable;
  } cmp_ctrl_t;

  localparam int CTRL_W = $bits(cmp_ctrl_t);

  localparam logic [1:0] SEL_CTRL    = 2'd0;
  localparam logic [1:0] SEL_ADDR    = 2'd1;
  localparam logic [1:0] SEL_DATA    = 2'd2;
  localparam logic [1:0] SEL_CLR_ARM = 2'd3;

endpackage

// File: rtl/dbgtrig_cmp.sv
module dbgtrig_cmp
  import dbgtrig_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 2,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             hi_ok_i,
  input  logic [AW-1:0]    hi_addr_i,
  input  logic [AW-1:0]    hi_data_i,
  input  logic             if_valid,
  input  logic [AW-1:0]    if_addr,
  input  logic             d_rd,
  input  logic             d_wr,
  input  logic [AW-1:0]    d_addr,
  input  logic [AW-1:0]    d_data,
  output cmp_ctrl_t        ctrl_o,
  output logic [AW-1:0]    addr_o,
  output logic [AW-1:0]    data_o,
  output logic             hit_o
);

  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX);

  cmp_ctrl_t     ctrl_q;
  logic [AW-1:0] addr_q, data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (cfg_we && cfg_idx == MY_IDX) begin
      case (cfg_sel)
        SEL_CTRL: ctrl_q <= cmp_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        SEL_ADDR: addr_q <= cfg_wdata;
        SEL_DATA: data_q <= cfg_wdata;
        default:  ;
      endcase
    end
  end

  logic d_act, in_if_rng, in_da_rng, in_dd_rng;

  always_comb begin
    d_act     = d_rd | d_wr;
    in_if_rng = hi_ok_i && (if_addr >= addr_q) && (if_addr <= hi_addr_i);
    in_da_rng = hi_ok_i && (d_addr  >= addr_q) && (d_addr  <= hi_addr_i);
    in_dd_rng = hi_ok_i && (d_data  >= data_q) && (d_data  <= hi_data_i);
    hit_o     = 1'b0;
    if (ctrl_q.enable) begin
      if (!ctrl_q.on_dbus) begin
        if (if_valid) begin
          case (ctrl_q.kind)
            K_ADDR:     hit_o = (if_addr == addr_q);
            K_RNG_ADDR: hit_o = in_if_rng;
            default:    hit_o = 1'b0;
          endcase
        end
      end else if (d_act) begin
        case (ctrl_q.kind)
          K_ADDR:     hit_o = (d_addr == addr_q);
          K_DATA:     hit_o = (d_data == data_q);
          K_READ:     hit_o = d_rd;
          K_WRITE:    hit_o = d_wr;
          K_RNG_ADDR: hit_o = in_da_rng;
          K_RNG_DATA: hit_o = in_dd_rng;
          K_RNG_BOTH: hit_o = in_da_rng & in_dd_rng;
          default:    hit_o = 1'b0;
        endcase
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  // an instruction-bus comparator never matches without a valid fetch
  assert_ibus_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !ctrl_q.on_dbus) |-> if_valid);
  assert_dbus_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && ctrl_q.on_dbus) |-> (d_rd || d_wr));

endmodule

// File: rtl/dbgtrig_chain.sv
module dbgtrig_chain
  import dbgtrig_pkg::*;
#(
  parameter int NCMP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  cmp_ctrl_t [NCMP-1:0]   ctrl_i,
  input  logic [NCMP-1:0]        hit_i,
  input  logic                   armed_i,
  input  logic                   d_act_i,
  output logic                   do_brk,
  output logic                   do_ext,
  output logic                   do_on,
  output logic                   do_off,
  output logic                   do_smp,
  output logic                   do_arm
);

  logic [NCMP-1:0] acc, ends, fire;

  for (genvar i = 0; i < NCMP; i++) begin : g_link
    if (i == 0) begin : g_head
      assign acc[i] = hit_i[i];
    end else begin : g_tail
      assign acc[i] = hit_i[i] &
        (ctrl_i[i-1].link ? (acc[i-1] & (ctrl_i[i-1].on_dbus == ctrl_i[i].on_dbus)) : 1'b1);
    end
    if (i == NCMP-1) begin : g_last
      assign ends[i] = 1'b1;
    end else begin : g_mid
      assign ends[i] = ~ctrl_i[i].link;
    end
    assign fire[i] = acc[i] & ends[i] & (~ctrl_i[i].need_arm | armed_i);

    assert_arm_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[i] && ctrl_i[i].need_arm) |-> armed_i);
  end

  always_comb begin
    do_brk = 1'b0;
    do_ext = 1'b0;
    do_on  = 1'b0;
    do_off = 1'b0;
    do_smp = 1'b0;
    do_arm = 1'b0;
    for (int i = 0; i < NCMP; i++) begin
      if (fire[i]) begin
        case (ctrl_i[i].action)
          A_BREAK:     do_brk = 1'b1;
          A_EXTTRIG:   do_ext = 1'b1;
          A_TRACE_ON:  do_on  = 1'b1;
          A_TRACE_OFF: do_off = 1'b1;
          A_SAMPLE:    do_smp = do_smp | ctrl_i[i].on_dbus;
          A_ARM:       do_arm = 1'b1;
          default:     ;
        endcase
      end
    end
  end

  assert_sample_dbus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_smp |-> d_act_i);

endmodule

// File: rtl/dbgtrig_act.sv
module dbgtrig_act #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_brk,
  input  logic          do_ext,
  input  logic          do_on,
  input  logic          do_off,
  input  logic          do_smp,
  input  logic          do_arm,
  input  logic          clr_arm,
  input  logic [AW-1:0] d_addr,
  input  logic [AW-1:0] d_data,
  input  logic          d_wr,
  input  logic          trc_ready,
  output logic          armed,
  output logic          brk_req,
  output logic          ext_trig,
  output logic          trace_en,
  output logic          trc_valid,
  output logic [AW-1:0] trc_addr,
  output logic [AW-1:0] trc_data,
  output logic          trc_wr
);

  logic slot_free;
  assign slot_free = ~trc_valid | trc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      brk_req   <= 1'b0;
      ext_trig  <= 1'b0;
      trace_en  <= 1'b0;
      trc_valid <= 1'b0;
      trc_addr  <= '0;
      trc_data  <= '0;
      trc_wr    <= 1'b0;
    end else begin
      brk_req  <= do_brk;
      ext_trig <= do_ext;
      if (clr_arm)     armed <= 1'b0;
      else if (do_arm) armed <= 1'b1;
      if (do_off)      trace_en <= 1'b0;
      else if (do_on)  trace_en <= 1'b1;
      if (do_smp && slot_free) begin
        trc_valid <= 1'b1;
        trc_addr  <= d_addr;
        trc_data  <= d_data;
        trc_wr    <= d_wr;
      end else if (trc_ready) begin
        trc_valid <= 1'b0;
      end
    end
  end

  assert_trc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && !trc_ready) |=> (trc_valid && $stable(trc_addr) && $stable(trc_data) && $stable(trc_wr)));
  assert_arm_persist_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clr_arm) |=> armed);
  assert_off_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_off |=> !trace_en);

endmodule

// File: rtl/dbg_trigger_ctl.sv
module dbg_trigger_ctl
  import dbgtrig_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NCMP = 4,
  localparam int IDX_W = $clog2(NCMP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             if_valid,
  input  logic [AW-1:0]    if_addr,
  input  logic             d_rd,
  input  logic             d_wr,
  input  logic [AW-1:0]    d_addr,
  input  logic [AW-1:0]    d_data,
  output logic             brk_req,
  output logic             ext_trig,
  output logic             trace_en,
  output logic             trc_valid,
  input  logic             trc_ready,
  output logic [AW-1:0]    trc_addr,
  output logic [AW-1:0]    trc_data,
  output logic             trc_wr
);

  cmp_ctrl_t [NCMP-1:0] ctrl;
  logic [NCMP-1:0][AW-1:0] cmp_addr, cmp_data;
  logic [NCMP-1:0] hit;
  logic armed, clr_arm;
  logic do_brk, do_ext, do_on, do_off, do_smp, do_arm;

  assign clr_arm = cfg_we && (cfg_sel == SEL_CLR_ARM);

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    logic          hi_ok;
    logic [AW-1:0] hi_a, hi_d;
    if (i < NCMP-1) begin : g_pair
      assign hi_ok = 1'b1;
      assign hi_a  = cmp_addr[i+1];
      assign hi_d  = cmp_data[i+1];
    end else begin : g_nopair
      assign hi_ok = 1'b0;
      assign hi_a  = '0;
      assign hi_d  = '0;
    end
    dbgtrig_cmp #(.AW(AW), .IDX_W(IDX_W), .IDX(i)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .hi_ok_i(hi_ok), .hi_addr_i(hi_a), .hi_data_i(hi_d),
      .if_valid(if_valid), .if_addr(if_addr),
      .d_rd(d_rd), .d_wr(d_wr), .d_addr(d_addr), .d_data(d_data),
      .ctrl_o(ctrl[i]), .addr_o(cmp_addr[i]), .data_o(cmp_data[i]), .hit_o(hit[i])
    );
  end

  dbgtrig_chain #(.NCMP(NCMP)) u_chain (
    .clk(clk), .rst_n(rst_n),
    .ctrl_i(ctrl), .hit_i(hit), .armed_i(armed), .d_act_i(d_rd | d_wr),
    .do_brk(do_brk), .do_ext(do_ext), .do_on(do_on), .do_off(do_off),
    .do_smp(do_smp), .do_arm(do_arm)
  );

  dbgtrig_act #(.AW(AW)) u_act (
    .clk(clk), .rst_n(rst_n),
    .do_brk(do_brk), .do_ext(do_ext), .do_on(do_on), .do_off(do_off),
    .do_smp(do_smp), .do_arm(do_arm), .clr_arm(clr_arm),
    .d_addr(d_addr), .d_data(d_data), .d_wr(d_wr), .trc_ready(trc_ready),
    .armed(armed), .brk_req(brk_req), .ext_trig(ext_trig), .trace_en(trace_en),
    .trc_valid(trc_valid), .trc_addr(trc_addr), .trc_data(trc_data), .trc_wr(trc_wr)
  );

  // break and external trigger appear only one cycle after a bus cycle
  assert_brk_after_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> ($past(if_valid) || $past(d_rd) || $past(d_wr)));
  assert_ext_after_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_trig) |-> ($past(if_valid) || $past(d_rd) || $past(d_wr)));

endmodule

// File: tb/dbg_trigger_ctl_test.sv
`timescale 1ns/1ps
module dbg_trigger_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        if_valid = 1'b0;
  logic [31:0] if_addr = '0;
  logic        d_rd = 1'b0, d_wr = 1'b0;
  logic [31:0] d_addr = '0, d_data = '0;
  logic        trc_ready = 1'b0;
  logic        brk_req, ext_trig, trace_en, trc_valid, trc_wr;
  logic [31:0] trc_addr, trc_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dbg_trigger_ctl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .if_valid(if_valid), .if_addr(if_addr), .d_rd(d_rd), .d_wr(d_wr),
    .d_addr(d_addr), .d_data(d_data), .brk_req(brk_req), .ext_trig(ext_trig),
    .trace_en(trace_en), .trc_valid(trc_valid), .trc_ready(trc_ready),
    .trc_addr(trc_addr), .trc_data(trc_data), .trc_wr(trc_wr)
  );

  localparam logic IBUS = 1'b0, DBUS = 1'b1;

  function automatic logic [31:0] mk(input logic bus, input logic [2:0] kind,
                                     input logic link, input logic narm, input logic [2:0] act);
    return {22'd0, act, narm, link, kind, bus, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic iv, input logic [31:0] ia, input logic rd, input logic wr,
                       input logic [31:0] da, input logic [31:0] dd);
    if_valid = iv; if_addr = ia; d_rd = rd; d_wr = wr; d_addr = da; d_data = dd;
    @(posedge clk);
    @(negedge clk);
    if_valid = 1'b0; d_rd = 1'b0; d_wr = 1'b0;
    #1;
  endtask

  task automatic idle();
    apply(1'b0, 32'd0, 1'b0, 1'b0, 32'd0, 32'd0);
  endtask

  task automatic cfg(input int idx, input logic [1:0] sel, input logic [31:0] val);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_sel = sel; cfg_wdata = val;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) cfg(i, 2'd0, 32'd0);
    cfg(0, 2'd3, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 brk_req", brk_req, 0);
    chk("R1 ext_trig", ext_trig, 0);
    chk("R1 trace_en", trace_en, 0);
    chk("R1 trc_valid", trc_valid, 0);
    apply(1'b1, 32'h0, 1'b1, 1'b0, 32'h0, 32'h0);
    chk("R1 disabled comparators", {brk_req, ext_trig, trc_valid}, 0);
  endtask

  task automatic t_breakpoint();
    cfg(0, 2'd1, 32'h100);
    cfg(0, 2'd0, mk(IBUS, 3'd0, 0, 0, 3'd0));
    apply(1'b1, 32'h100, 0, 0, 0, 0);
    chk("R4 break on fetch", brk_req, 1);
    idle();
    chk("R4 break one cycle", brk_req, 0);
    apply(1'b1, 32'h104, 0, 0, 0, 0);
    chk("R4 other fetch", brk_req, 0);
    apply(1'b0, 32'h0, 1, 0, 32'h100, 0);
    chk("R4 data access ignored", brk_req, 0);
    apply(1'b0, 32'h100, 0, 0, 0, 0);
    chk("R3 fetch needs if_valid", brk_req, 0);
    clear_all();
  endtask

  task automatic t_data_kinds();
    cfg(0, 2'd1, 32'h200);
    cfg(0, 2'd2, 32'hCAFE);
    cfg(0, 2'd0, mk(DBUS, 3'd0, 0, 0, 3'd1));
    apply(0, 0, 1, 0, 32'h200, 0);
    chk("R3 data addr hit", ext_trig, 1);
    idle();
    chk("R8 ext one cycle", ext_trig, 0);
    apply(0, 0, 1, 0, 32'h201, 0);
    chk("R3 data addr miss", ext_trig, 0);
    apply(0, 0, 0, 0, 32'h200, 0);
    chk("R3 no strobe", ext_trig, 0);
    cfg(0, 2'd0, mk(DBUS, 3'd1, 0, 0, 3'd1));
    apply(0, 0, 0, 1, 32'h5, 32'hCAFE);
    chk("R3 data value hit", ext_trig, 1);
    apply(0, 0, 0, 1, 32'h5, 32'hCAFF);
    chk("R3 data value miss", ext_trig, 0);
    cfg(0, 2'd0, mk(DBUS, 3'd2, 0, 0, 3'd1));
    apply(0, 0, 0, 1, 0, 0);
    chk("R3 read kind on write", ext_trig, 0);
    apply(0, 0, 1, 0, 0, 0);
    chk("R3 read kind on read", ext_trig, 1);
    cfg(0, 2'd0, mk(DBUS, 3'd3, 0, 0, 3'd1));
    apply(0, 0, 1, 0, 0, 0);
    chk("R3 write kind on read", ext_trig, 0);
    apply(0, 0, 0, 1, 0, 0);
    chk("R3 write kind on write", ext_trig, 1);
    clear_all();
  endtask

  task automatic t_link();
    cfg(0, 2'd0, mk(DBUS, 3'd3, 1, 0, 3'd6));
    cfg(1, 2'd1, 32'h300);
    cfg(1, 2'd0, mk(DBUS, 3'd0, 0, 0, 3'd1));
    apply(0, 0, 0, 1, 32'h300, 0);
    chk("R5 write AND addr", ext_trig, 1);
    apply(0, 0, 1, 0, 32'h300, 0);
    chk("R5 read fails AND", ext_trig, 0);
    apply(0, 0, 0, 1, 32'h304, 0);
    chk("R5 addr fails AND", ext_trig, 0);
    cfg(0, 2'd1, 32'h300);
    cfg(0, 2'd0, mk(IBUS, 3'd0, 1, 0, 3'd6));
    apply(1, 32'h300, 0, 1, 32'h300, 0);
    chk("R5 mixed-bus chain", ext_trig, 0);
    clear_all();
  endtask

  task automatic t_range();
    cfg(0, 2'd1, 32'h1000);
    cfg(1, 2'd1, 32'h10FF);
    cfg(0, 2'd0, mk(DBUS, 3'd4, 0, 0, 3'd1));
    apply(0, 0, 1, 0, 32'h1000, 0);
    chk("R6 low bound", ext_trig, 1);
    apply(0, 0, 1, 0, 32'h10FF, 0);
    chk("R6 high bound", ext_trig, 1);
    apply(0, 0, 1, 0, 32'h0FFF, 0);
    chk("R6 below", ext_trig, 0);
    apply(0, 0, 1, 0, 32'h1100, 0);
    chk("R6 above", ext_trig, 0);
    cfg(0, 2'd2, 32'd10);
    cfg(1, 2'd2, 32'd20);
    cfg(0, 2'd0, mk(DBUS, 3'd5, 0, 0, 3'd1));
    apply(0, 0, 0, 1, 0, 32'd20);
    chk("R6 data high bound", ext_trig, 1);
    apply(0, 0, 0, 1, 0, 32'd21);
    chk("R6 data above", ext_trig, 0);
    cfg(0, 2'd0, mk(DBUS, 3'd6, 0, 0, 3'd1));
    apply(0, 0, 0, 1, 32'h1010, 32'd10);
    chk("R6 both in", ext_trig, 1);
    apply(0, 0, 0, 1, 32'h1200, 32'd10);
    chk("R6 both addr out", ext_trig, 0);
    cfg(2, 2'd1, 32'h40);
    cfg(3, 2'd1, 32'h4F);
    cfg(2, 2'd0, mk(IBUS, 3'd4, 0, 0, 3'd0));
    apply(1, 32'h4F, 0, 0, 0, 0);
    chk("R6 fetch range", brk_req, 1);
    cfg(3, 2'd0, mk(IBUS, 3'd4, 0, 0, 3'd0));
    cfg(2, 2'd0, 32'd0);
    apply(1, 32'h4F, 0, 0, 0, 0);
    chk("R6 last comparator range", brk_req, 0);
    clear_all();
  endtask

  task automatic t_arm();
    cfg(0, 2'd1, 32'h500);
    cfg(0, 2'd0, mk(IBUS, 3'd0, 0, 0, 3'd5));
    cfg(1, 2'd1, 32'h600);
    cfg(1, 2'd0, mk(IBUS, 3'd0, 0, 1, 3'd0));
    apply(1, 32'h600, 0, 0, 0, 0);
    chk("R7 B before A", brk_req, 0);
    apply(1, 32'h500, 0, 0, 0, 0);
    chk("R7 A arms only", brk_req, 0);
    apply(1, 32'h600, 0, 0, 0, 0);
    chk("R7 B after A", brk_req, 1);
    idle();
    apply(1, 32'h600, 0, 0, 0, 0);
    chk("R7 armed persists", brk_req, 1);
    cfg(2, 2'd3, 32'd0);
    apply(1, 32'h600, 0, 0, 0, 0);
    chk("R2 clear command disarms", brk_req, 0);
    clear_all();
  endtask

  task automatic t_trace();
    cfg(0, 2'd1, 32'h700);
    cfg(0, 2'd0, mk(DBUS, 3'd0, 0, 0, 3'd2));
    cfg(1, 2'd2, 32'h55);
    cfg(1, 2'd0, mk(DBUS, 3'd1, 0, 0, 3'd3));
    apply(0, 0, 1, 0, 32'h700, 32'h0);
    chk("R8 trace on", trace_en, 1);
    idle();
    chk("R8 trace level holds", trace_en, 1);
    apply(0, 0, 1, 0, 32'h700, 32'h55);
    chk("R8 off wins", trace_en, 0);
    clear_all();
  endtask

  task automatic t_sample();
    trc_ready = 1'b0;
    cfg(0, 2'd0, mk(DBUS, 3'd3, 0, 0, 3'd4));
    apply(0, 0, 0, 1, 32'h800, 32'h11);
    chk("R9 sample valid", trc_valid, 1);
    chk("R9 sample addr", trc_addr, 32'h800);
    chk("R9 sample data", trc_data, 32'h11);
    chk("R9 sample wr", trc_wr, 1);
    apply(0, 0, 0, 1, 32'h804, 32'h22);
    chk("R10 held under backpressure", trc_addr, 32'h800);
    chk("R10 valid held", trc_valid, 1);
    trc_ready = 1'b1;
    idle();
    chk("R10 consumed", trc_valid, 0);
    cfg(0, 2'd0, 32'd0);
    cfg(1, 2'd1, 32'h900);
    cfg(1, 2'd0, mk(IBUS, 3'd0, 0, 0, 3'd4));
    apply(1, 32'h900, 0, 0, 0, 0);
    chk("R9 fetch cannot sample", trc_valid, 0);
    trc_ready = 1'b0;
    clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_breakpoint();
    t_data_kinds();
    t_link();
    t_range();
    t_arm();
    t_trace();
    t_sample();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule